// File: doc/BRIEF.md
# Key-protected device control block

This block is a small register bank for a system-on-chip. It holds the configuration fields that switch peripherals on and off, and a reset register for two RMII Ethernet interfaces. A simple single-cycle register bus reaches it: address, write strobe and write data are sampled on the rising clock edge, and read data is a combinational function of the address. Protected registers drop writes unless an unlock sequence has been performed. Those dropped writes raise no error and leave the stored value unchanged.

There are two kinds of protection. The first control register (group A) is guarded by a lock register. Writing the correct key opens the lock, and it shuts again by itself after a short window. Writing zero or any wrong value shuts it at once. The second control register (group B) and the RMII reset register are guarded by a pair of kick registers. Both must hold their own key before any write to those registers is accepted, and writing zero to either kick register locks them again. Every device owns one contiguous field. Group A fields are freely rewritable. Group B fields are enable-only: once a field holds its enable code, it can never be changed again. A status register shows, for each device, the settled on/off state. This state follows the control field after a fixed settling latency.

The lock runs through a state machine with states LK_SHUT and LK_OPEN:
- Key write: LK_SHUT to LK_OPEN, or a restart of the window while open.
- Window expiry: LK_OPEN to LK_SHUT.
- Zero or wrong value: any state to LK_SHUT.

The kick pair runs through KK_LOCKED, KK_HAVE0, KK_HAVE1 and KK_OPEN:
- A correct key in either kick register adds that half.
- Any other value in a kick register removes that half.
- KK_OPEN is reached only when both halves are held.

Each device's status tracker uses ST_IDLE and ST_SETTLE:
- Entry: a control change moves it from ST_IDLE to ST_SETTLE.
- Restart: a further change while settling restarts the count.
- Commit: at the end of the count, the new state is published and the tracker returns to ST_IDLE.

Top module: `devctl_guard`

## Requirements
- R1: After reset:
  - Group A register (address 0) reads 0x55: every 2-bit field holds its disable code 01.
  - Group B register (address 2), the lock (address 1), both kick registers (addresses 3, 4), status (address 5) and the RMII reset register (address 6) read 0.
  - `dev_en` and `rmii_rst` are 0.
- R2: A write to address 0 while the lock is shut is dropped. This includes the case where the last lock write was a wrong key.
- R3: Writing the key 0x8A3C51E7 to address 1 opens the lock. A write to address 0 is accepted on any of the RELOCK (default 4) clock edges after the key edge. A write on the edge after that is dropped, and the lock then reads 0.
- R4: Writing 0 to address 1 shuts the lock for the very next edge, even inside the window.
- R5: Writes to addresses 2 and 6 are accepted only after address 3 holds key 0x13579BDF and address 4 holds key 0x2468ACE0. One of the two keys alone leaves them dropped.
- R6: Writing 0 to either kick register locks addresses 2 and 6 again. That kick register then reads 0.
- R7: Device d (0..3) uses bits [2d+1:2d] of address 0. Enable code 11 sets `dev_en[d]`, and any other code clears it. A field can be rewritten to disable.
- R8: Device 4+j (j = 0..3) uses bit 4+j of address 2, with enable code 1. Once a field holds 1, a later write of 0 to it is ignored while other fields still take their values.
- R9: Bit d of the status register (address 5) takes the value of `dev_en[d]` exactly LAT+1 (default 9) edges after the write edge that changed it. It still shows the old value LAT edges after.
- R10: Bits [1:0] of address 6 drive `rmii_rst[1:0]`. A 1 asserts that interface's reset, and a 0 releases it.
- R11: Bit 0 of the lock register reads 1 while the lock is open. Bit 0 of each kick register reads 1 while it holds its key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (3) | Register word address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| dev_en | output | NUM_A+NUM_B (8) | Per-device enable derived from the control fields |
| rmii_rst | output | NUM_RST (2) | Reset lines of the two RMII interfaces |

## Verification
The hardest situations to reach from the ports are the last cycle of the self-closing lock window and the exact edge on which a status bit settles. Both depend on counting clock edges from a particular write, not on any visible handshake. The stimulus inserts a precise number of idle cycles after the key write: one write lands on the final open edge and another lands one edge later. Status is read on the edge before and the edge of its change, in both directions. The enable-only property is exercised by writing a mixed word that tries to disable set fields while enabling clear ones.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

    // Word addresses of the register bank
    localparam int REG_CTRL_A = 0;
    localparam int REG_LOCK_A = 1;
    localparam int REG_CTRL_B = 2;
    localparam int REG_KICK0  = 3;
    localparam int REG_KICK1  = 4;
    localparam int REG_STATUS = 5;
    localparam int REG_RST    = 6;

    typedef enum logic {
        LK_SHUT,
        LK_OPEN
    } lock_state_e;

    typedef enum logic [1:0] {
        KK_LOCKED,
        KK_HAVE0,
        KK_HAVE1,
        KK_OPEN
    } kick_state_e;

    typedef enum logic {
        ST_IDLE,
        ST_SETTLE
    } settle_state_e;

endpackage

// File: rtl/devctl_keylock.sv
// Single-key lock that reopens on a key write and closes after RELOCK edges (R3, R4)
module devctl_keylock
    import devctl_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY    = 32'h8A3C_51E7,
    parameter int                RELOCK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              is_open
);
    localparam int CW = (RELOCK > 1) ? $clog2(RELOCK) : 1;

    lock_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (key_wr) begin
            if (key_data == KEY) begin
                st_d  = LK_OPEN;
                cnt_d = CW'(RELOCK - 1);
            end else begin
                st_d  = LK_SHUT;
                cnt_d = '0;
            end
        end else begin
            unique case (st_q)
                LK_SHUT: begin
                    cnt_d = '0;
                end
                LK_OPEN: begin
                    if (cnt_q == '0) begin
                        st_d = LK_SHUT;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LK_SHUT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        is_open = (st_q == LK_OPEN);
    end

endmodule

// File: rtl/devctl_kick.sv
// Two-register kick unlock (R5, R6)
module devctl_kick
    import devctl_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY0   = 32'h1357_9BDF,
    parameter logic [DATA_W-1:0] KEY1   = 32'h2468_ACE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0,
    input  logic              wr1,
    input  logic [DATA_W-1:0] wdata,
    output logic              is_open,
    output logic              held0,
    output logic              held1
);
    kick_state_e st_q, st_d;
    logic h0, h1;

    always_comb begin
        h0 = (st_q == KK_HAVE0) || (st_q == KK_OPEN);
        h1 = (st_q == KK_HAVE1) || (st_q == KK_OPEN);
        if (wr0) h0 = (wdata == KEY0);
        if (wr1) h1 = (wdata == KEY1);
        unique case ({h1, h0})
            2'b00: st_d = KK_LOCKED;
            2'b01: st_d = KK_HAVE0;
            2'b10: st_d = KK_HAVE1;
            2'b11: st_d = KK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KK_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        is_open = 1'b0;
        held0   = 1'b0;
        held1   = 1'b0;
        unique case (st_q)
            KK_LOCKED: ;
            KK_HAVE0:  held0 = 1'b1;
            KK_HAVE1:  held1 = 1'b1;
            KK_OPEN: begin
                held0   = 1'b1;
                held1   = 1'b1;
                is_open = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/devctl_settle.sv
// Per-device status tracker: publishes the control state after LAT+1 edges (R9)
module devctl_settle
    import devctl_pkg::*;
#(
    parameter int LAT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    output logic stat
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    settle_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          tgt_q, tgt_d;
    logic          stat_q, stat_d;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        tgt_d  = tgt_q;
        stat_d = stat_q;
        unique case (st_q)
            ST_IDLE: begin
                if (want != stat_q) begin
                    st_d  = ST_SETTLE;
                    cnt_d = CW'(LAT - 1);
                    tgt_d = want;
                end
            end
            ST_SETTLE: begin
                if (want != tgt_q) begin
                    tgt_d = want;
                    cnt_d = CW'(LAT - 1);
                    if (want == stat_q) st_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    stat_d = tgt_q;
                    st_d   = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            tgt_q  <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            tgt_q  <= tgt_d;
            stat_q <= stat_d;
        end
    end

    always_comb begin
        stat = stat_q;
    end

endmodule

// File: rtl/devctl_guard.sv
module devctl_guard
    import devctl_pkg::*;
#(
    parameter int                ADDR_W    = 3,
    parameter int                DATA_W    = 32,
    parameter int                NUM_A     = 4,
    parameter int                WA        = 2,
    parameter int                LSB_A     = 0,
    parameter logic [WA-1:0]     EN_A      = 2'b11,
    parameter logic [WA-1:0]     DIS_A     = 2'b01,
    parameter int                NUM_B     = 4,
    parameter int                WB        = 1,
    parameter int                LSB_B     = 4,
    parameter logic [WB-1:0]     EN_B      = 1'b1,
    parameter logic [WB-1:0]     DIS_B     = 1'b0,
    parameter int                NUM_RST   = 2,
    parameter int                RELOCK    = 4,
    parameter int                LAT       = 8,
    parameter logic [DATA_W-1:0] LOCK_KEY  = 32'h8A3C_51E7,
    parameter logic [DATA_W-1:0] KICK_KEY0 = 32'h1357_9BDF,
    parameter logic [DATA_W-1:0] KICK_KEY1 = 32'h2468_ACE0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_A+NUM_B-1:0]   dev_en,
    output logic [NUM_RST-1:0]       rmii_rst
);
    localparam int NUM_DEV = NUM_A + NUM_B;
    localparam int A_BITS  = NUM_A * WA;
    localparam int B_BITS  = NUM_B * WB;

    logic wr_ctrl_a, wr_lock, wr_ctrl_b, wr_kick0, wr_kick1, wr_rst;
    logic lock_open, kick_open, kick_h0, kick_h1;

    logic [A_BITS-1:0]  ctrl_a_q, ctrl_a_d;
    logic [B_BITS-1:0]  ctrl_b_q, ctrl_b_d;
    logic [NUM_RST-1:0] rst_q, rst_d;
    logic [NUM_DEV-1:0] stat_vec;

    always_comb begin
        wr_ctrl_a = bus_we && (bus_addr == ADDR_W'(REG_CTRL_A));
        wr_lock   = bus_we && (bus_addr == ADDR_W'(REG_LOCK_A));
        wr_ctrl_b = bus_we && (bus_addr == ADDR_W'(REG_CTRL_B));
        wr_kick0  = bus_we && (bus_addr == ADDR_W'(REG_KICK0));
        wr_kick1  = bus_we && (bus_addr == ADDR_W'(REG_KICK1));
        wr_rst    = bus_we && (bus_addr == ADDR_W'(REG_RST));
    end

    devctl_keylock #(
        .DATA_W (DATA_W),
        .KEY    (LOCK_KEY),
        .RELOCK (RELOCK)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_lock),
        .key_data (bus_wdata),
        .is_open  (lock_open)
    );

    devctl_kick #(
        .DATA_W (DATA_W),
        .KEY0   (KICK_KEY0),
        .KEY1   (KICK_KEY1)
    ) u_kick (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr0     (wr_kick0),
        .wr1     (wr_kick1),
        .wdata   (bus_wdata),
        .is_open (kick_open),
        .held0   (kick_h0),
        .held1   (kick_h1)
    );

    // Group A: freely rewritable fields, lock-protected (R2, R7)
    always_comb begin
        ctrl_a_d = ctrl_a_q;
        if (wr_ctrl_a && lock_open) ctrl_a_d = bus_wdata[LSB_A +: A_BITS];
    end

    // Group B: enable-only fields, kick-protected (R5, R8)
    for (genvar j = 0; j < NUM_B; j++) begin : g_fld_b
        assign ctrl_b_d[j*WB +: WB] =
            (wr_ctrl_b && kick_open && (ctrl_b_q[j*WB +: WB] != EN_B))
                ? bus_wdata[LSB_B + j*WB +: WB]
                : ctrl_b_q[j*WB +: WB];
    end

    // RMII reset mask, kick-protected (R10)
    always_comb begin
        rst_d = rst_q;
        if (wr_rst && kick_open) rst_d = bus_wdata[NUM_RST-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a_q <= {NUM_A{DIS_A}};
            ctrl_b_q <= {NUM_B{DIS_B}};
            rst_q    <= '0;
        end else begin
            ctrl_a_q <= ctrl_a_d;
            ctrl_b_q <= ctrl_b_d;
            rst_q    <= rst_d;
        end
    end

    for (genvar d = 0; d < NUM_A; d++) begin : g_en_a
        assign dev_en[d] = (ctrl_a_q[d*WA +: WA] == EN_A);
    end

    for (genvar j = 0; j < NUM_B; j++) begin : g_en_b
        assign dev_en[NUM_A + j] = (ctrl_b_q[j*WB +: WB] == EN_B);
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_settle
        devctl_settle #(
            .LAT (LAT)
        ) u_settle (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (dev_en[d]),
            .stat  (stat_vec[d])
        );
    end

    assign rmii_rst = rst_q;

    // Register read mux (R11 for lock and kick flags)
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_CTRL_A): bus_rdata = DATA_W'(ctrl_a_q) << LSB_A;
            ADDR_W'(REG_LOCK_A): bus_rdata = DATA_W'(lock_open);
            ADDR_W'(REG_CTRL_B): bus_rdata = DATA_W'(ctrl_b_q) << LSB_B;
            ADDR_W'(REG_KICK0):  bus_rdata = DATA_W'(kick_h0);
            ADDR_W'(REG_KICK1):  bus_rdata = DATA_W'(kick_h1);
            ADDR_W'(REG_STATUS): bus_rdata = DATA_W'(stat_vec);
            ADDR_W'(REG_RST):    bus_rdata = DATA_W'(rst_q);
            default:             bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/devctl_guard_chk.sv
module devctl_guard_chk
    import devctl_pkg::*;
#(
    parameter int                ADDR_W   = 3,
    parameter int                DATA_W   = 32,
    parameter int                NUM_A    = 4,
    parameter int                NUM_B    = 4,
    parameter int                A_BITS   = 8,
    parameter int                B_BITS   = 4,
    parameter int                NUM_RST  = 2,
    parameter int                RELOCK   = 4,
    parameter logic [DATA_W-1:0] LOCK_KEY = 32'h8A3C_51E7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic                   lock_open,
    input logic                   kick_open,
    input logic [A_BITS-1:0]      ctrl_a_q,
    input logic [B_BITS-1:0]      ctrl_b_q,
    input logic [NUM_RST-1:0]     rst_q,
    input logic [NUM_A+NUM_B-1:0] dev_en
);
    localparam int RW = $clog2(RELOCK + 2) + 1;
    localparam logic [NUM_A+NUM_B-1:0] B_MASK = {{NUM_B{1'b1}}, {NUM_A{1'b0}}};

    logic [RW-1:0] run_q;
    logic key_hit;

    assign key_hit = bus_we && (bus_addr == ADDR_W'(REG_LOCK_A)) && (bus_wdata == LOCK_KEY);

    // Cycles the lock has been open since the last correct key
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (key_hit)   run_q <= RW'(1);
        else if (lock_open) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    p_drop_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(REG_CTRL_A) && !lock_open) |=> $stable(ctrl_a_q));

    p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_open |-> (run_q != '0 && run_q <= RW'(RELOCK)));

    p_zero_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(REG_LOCK_A) && bus_wdata == '0) |=> !lock_open);

    p_kick_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == ADDR_W'(REG_CTRL_B) || bus_addr == ADDR_W'(REG_RST)) && !kick_open)
        |=> ($stable(ctrl_b_q) && $stable(rst_q)));

    p_kick_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == ADDR_W'(REG_KICK0) || bus_addr == ADDR_W'(REG_KICK1)) && bus_wdata == '0)
        |=> !kick_open);

    p_sticky_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(dev_en) & ~dev_en & B_MASK) == '0));

endmodule

bind devctl_guard devctl_guard_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_A    (NUM_A),
    .NUM_B    (NUM_B),
    .A_BITS   (A_BITS),
    .B_BITS   (B_BITS),
    .NUM_RST  (NUM_RST),
    .RELOCK   (RELOCK),
    .LOCK_KEY (LOCK_KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .lock_open (lock_open),
    .kick_open (kick_open),
    .ctrl_a_q  (ctrl_a_q),
    .ctrl_b_q  (ctrl_b_q),
    .rst_q     (rst_q),
    .dev_en    (dev_en)
);

// File: tb/devctl_guard_bench.sv
`timescale 1ns/1ps
module devctl_guard_bench;

    localparam int          LAT  = 8;
    localparam logic [31:0] LKEY = 32'h8A3C_51E7;
    localparam logic [31:0] KK0  = 32'h1357_9BDF;
    localparam logic [31:0] KK1  = 32'h2468_ACE0;

    localparam logic [2:0] A_CA = 3'd0, A_LK = 3'd1, A_CB = 3'd2, A_K0 = 3'd3,
                           A_K1 = 3'd4, A_ST = 3'd5, A_RS = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  dev_en;
    logic [1:0]  rmii_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    devctl_guard u_devctl_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dev_en    (dev_en),
        .rmii_rst  (rmii_rst)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 30;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, 3'd0, 32'h0,         32'h55, 4'd1},  // R1 group A reset codes
        '{1'b0, 3'd5, 32'h0,         32'h0,  4'd1},  // R1 status clear
        '{1'b1, 3'd0, 32'hFF,        32'h0,  4'd2},  // R2 write while shut
        '{1'b0, 3'd0, 32'h0,         32'h55, 4'd2},
        '{1'b1, 3'd1, 32'h0000_1234, 32'h0,  4'd2},  // R2 wrong key
        '{1'b1, 3'd0, 32'hFF,        32'h0,  4'd2},
        '{1'b0, 3'd0, 32'h0,         32'h55, 4'd2},
        '{1'b0, 3'd1, 32'h0,         32'h0,  4'd2},
        '{1'b1, 3'd1, 32'h8A3C_51E7, 32'h0,  4'd7},  // R7 key then write
        '{1'b1, 3'd0, 32'hC7,        32'h0,  4'd7},
        '{1'b0, 3'd0, 32'h0,         32'hC7, 4'd7},
        '{1'b1, 3'd1, 32'h0,         32'h0,  4'd4},  // R4 zero shuts early
        '{1'b1, 3'd0, 32'h00,        32'h0,  4'd4},
        '{1'b0, 3'd0, 32'h0,         32'hC7, 4'd4},
        '{1'b0, 3'd1, 32'h0,         32'h0,  4'd4},
        '{1'b1, 3'd3, 32'h1357_9BDF, 32'h0,  4'd5},  // R5 one kick only
        '{1'b1, 3'd2, 32'hF0,        32'h0,  4'd5},
        '{1'b0, 3'd2, 32'h0,         32'h0,  4'd5},
        '{1'b1, 3'd4, 32'h2468_ACE0, 32'h0,  4'd11}, // R11 kick flags
        '{1'b0, 3'd4, 32'h0,         32'h1,  4'd11},
        '{1'b1, 3'd2, 32'h50,        32'h0,  4'd8},  // R8 enable 4 and 6
        '{1'b0, 3'd2, 32'h0,         32'h50, 4'd8},
        '{1'b1, 3'd2, 32'hA0,        32'h0,  4'd8},  // R8 try disabling 4 and 6
        '{1'b0, 3'd2, 32'h0,         32'hF0, 4'd8},
        '{1'b1, 3'd6, 32'h3,         32'h0,  4'd10}, // R10 reset mask
        '{1'b0, 3'd6, 32'h0,         32'h3,  4'd10},
        '{1'b1, 3'd6, 32'h1,         32'h0,  4'd10},
        '{1'b1, 3'd3, 32'h0,         32'h0,  4'd6},  // R6 relock by zero
        '{1'b1, 3'd6, 32'h0,         32'h0,  4'd6},
        '{1'b0, 3'd6, 32'h0,         32'h1,  4'd6}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        bus_we = 1'b0;
        idle(3);
        rst_n  = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        do_reset();

        // R1 reset state of the remaining registers and outputs
        rd(A_CB, v); chk("R1 group B", v, 32'h0);
        rd(A_LK, v); chk("R1 lock", v, 32'h0);
        rd(A_K0, v); chk("R1 kick0", v, 32'h0);
        rd(A_RS, v); chk("R1 rmii reg", v, 32'h0);
        chk("R1 dev_en", 32'(dev_en), 32'h0);
        chk("R1 rmii_rst", 32'(rmii_rst), 32'h0);

        // Vector table: one bus cycle per step
        for (int i = 0; i < NSTEP; i++) begin
            if (STEPS[i].wr) begin
                bus_we    = 1'b1;
                bus_addr  = STEPS[i].addr;
                bus_wdata = STEPS[i].data;
                @(negedge clk);
                bus_we    = 1'b0;
            end else begin
                rd(STEPS[i].addr, v);
                chk($sformatf("R%0d step %0d", STEPS[i].req, i), v, STEPS[i].exp);
                @(negedge clk);
            end
        end

        chk("R7 R8 dev_en after table", 32'(dev_en), 32'hF9);
        chk("R10 rmii_rst after table", 32'(rmii_rst), 32'h1);
        idle(LAT + 2);
        rd(A_ST, v); chk("R9 settled status", v, 32'hF9);

        // R3 window boundary and R9 rise latency
        do_reset();
        wr(A_LK, LKEY);
        idle(3);
        wr(A_CA, 32'h03);                  // lands on the last open edge
        rd(A_CA, v); chk("R3 last window edge", v, 32'h03);
        rd(A_LK, v); chk("R3 lock shut after window", v, 32'h0);
        chk("R7 dev0 enabled", 32'(dev_en), 32'h01);
        idle(LAT);
        rd(A_ST, v); chk("R9 status before settle", v, 32'h0);
        idle(1);
        rd(A_ST, v); chk("R9 status at settle", v, 32'h1);

        wr(A_LK, LKEY);
        rd(A_LK, v); chk("R11 lock open flag", v, 32'h1);
        idle(4);
        wr(A_CA, 32'hC0);                  // one edge past the window
        rd(A_CA, v); chk("R3 write after window dropped", v, 32'h03);

        // R7 group A can be disabled again; R9 fall latency
        wr(A_LK, LKEY);
        wr(A_CA, 32'h01);
        chk("R7 dev0 disabled", 32'(dev_en), 32'h00);
        idle(LAT);
        rd(A_ST, v); chk("R9 status hold before fall", v, 32'h1);
        idle(1);
        rd(A_ST, v); chk("R9 status fall", v, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule